// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter Unit

This block holds two timer/counter channels. Each channel keeps a low count byte and a high count byte, and it runs in one of four modes. The modes are a 13-bit count, a 16-bit count, an 8-bit count that reloads itself, and a split mode. A channel counts either machine cycles or falling edges on its own count pin. A machine cycle is one core clock in every `PRESCALE` clocks. Counting can also be gated by an external level pin. When a channel rolls over, it sets an overflow flag, and this flag drives an output that an interrupt controller can use.

Software reaches the unit through a byte-wide register port. Writes take effect at a clock edge, and reads come back combinationally. Through this port software loads and reads the count bytes, sets the configuration of both channels in one mode byte, and starts, stops and clears the channels through one control byte. In split mode channel 0 becomes two separate 8-bit counters. Its high byte then uses the run bit and flag of channel 1, and channel 1 keeps its count frozen.

Top module: `tmr_pair_unit`

## Requirements
- R1: Register map on `cpu_addr`:
  - 0 is the channel 0 low byte, 1 is the channel 0 high byte, 2 is the channel 1 low byte and 3 is the channel 1 high byte.
  - 4 is the mode byte. Channel 0 uses bits [3:0] and channel 1 uses bits [7:4]. Within each nibble, bits [1:0] select the mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split), bit 2 selects the pin as count source and bit 3 enables gating.
  - 5 is the control byte: bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1.
  - Every byte reads back the value last written or counted, and addresses 6 and 7 read as 0.
- R2: Reset clears all count bytes, the mode byte, the control byte and both `ovf_flag` outputs.
- R3: A channel advances only when its run bit is 1 and either its gate bit is 0 or its `gate_pin` bit is 1.
- R4: With the source bit at 0, a channel advances once in every `PRESCALE` (default 12) clocks. With the source bit at 1, it advances once for each high-to-low transition of its `cnt_pin` bit, and the new value is readable after the second rising clock edge following the fall.
- R5: Mode 0 counts a 13-bit value. The high byte sits above the low `M0_LO_BITS` (default 5) bits of the low byte. The upper low-byte bits keep their value and play no part in the count, and the flag is set when the 13-bit value rolls from all ones to zero.
- R6: Mode 1 counts all 16 bits, and the rollover from 0xFFFF to 0x0000 sets the flag.
- R7: In mode 2 the low byte counts. On a step from 0xFF it loads the high byte and sets the flag, and the high byte does not change.
- R8: When channel 0 is in mode 3, its low byte is an 8-bit counter under channel 0's source, gate, run and flag. Its high byte counts machine cycles while run 1 is set and sets flag 1 when it rolls over.
- R9: Channel 1 holds its count while it is in mode 3 or while channel 0 is in mode 3.
- R10: Setting a run bit does not change the count bytes.
- R11: A write to the control byte loads both flags from bits 2 and 3, so writing 0 clears a flag. A high `irq_ack` bit for one clock clears the matching flag, except when an overflow sets that flag in the same cycle.
- R12: A write to a count byte takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| gate_pin | input | 2 | Per-channel external gate level |
| cnt_pin | input | 2 | Per-channel external count pin |
| irq_ack | input | 2 | Per-channel flag clear pulse |
| ovf_flag | output | 2 | Per-channel overflow flags |

## Verification
The result of a write, whether a register load, a flag change or a run bit, can be read at the falling edge right after the clock edge that takes it. Reads are combinational. A pin fall driven at a falling edge is counted at the second rising edge after it, so the bench holds the pin low for one cycle and reads the result one full cycle after the pin returns high. Machine-cycle counting is checked over windows of exactly 12·N counted edges, from the edge that sets a run bit to the edge that clears it, because such a window always contains N prescaler ticks whatever the prescaler phase. Where a tick may fall on an unknown edge, the bench samples only once enough edges have passed to guarantee the result.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      MD_13BIT  = 2'd0,
      MD_16BIT  = 2'd1,
      MD_RELOAD = 2'd2,
      MD_SPLIT  = 2'd3
   } tmode_e;

   // One nibble of the mode byte: [3] gate enable, [2] pin source, [1:0] mode
   typedef struct packed {
      logic   gate_en;
      logic   ext_src;
      tmode_e mode;
   } chcfg_t;

   localparam logic [2:0] A_LO0  = 3'd0;
   localparam logic [2:0] A_HI0  = 3'd1;
   localparam logic [2:0] A_LO1  = 3'd2;
   localparam logic [2:0] A_HI1  = 3'd3;
   localparam logic [2:0] A_MODE = 3'd4;
   localparam logic [2:0] A_CTRL = 3'd5;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int PRESCALE = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic mc_tick
);
   localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
   localparam logic [CW-1:0] STEP = CW'(1);

   logic [CW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              div_q <= '0;
      else if (div_q == LAST)  div_q <= '0;
      else                     div_q <= div_q + STEP;
   end

   assign mc_tick = (div_q == LAST);
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   logic smp_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= 1'b1;
         prev_q <= 1'b1;
      end else begin
         smp_q  <= pin;
         prev_q <= smp_q;
      end
   end

   // one event per high-to-low transition seen on two successive samples
   assign fall = prev_q & ~smp_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pair_pkg::*;
#(
   parameter bit SPLIT_OK   = 1'b0,
   parameter int M0_LO_BITS = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  tmode_e mode,
   input  logic   cnt_en,
   input  logic   hi_en,
   input  logic   wr_lo,
   input  logic   wr_hi,
   input  byte_t  wdata,
   output byte_t  lo_q,
   output byte_t  hi_q,
   output logic   ovf_main,
   output logic   ovf_split
);
   localparam int W16 = 2 * BYTE_W;
   localparam byte_t               ONE_B  = byte_t'(1);
   localparam logic [W16-1:0]      ONE_W  = W16'(1);
   localparam logic [M0_LO_BITS-1:0] ONE_M0 = M0_LO_BITS'(1);

   byte_t lo_d, hi_d;
   logic  main_raw, split_raw;
   logic [W16-1:0] wide_nx;

   assign wide_nx = {hi_q, lo_q} + ONE_W;

   always_comb begin
      lo_d      = lo_q;
      hi_d      = hi_q;
      main_raw  = 1'b0;
      split_raw = 1'b0;
      unique case (mode)
         MD_13BIT: if (cnt_en) begin
            lo_d[M0_LO_BITS-1:0] = lo_q[M0_LO_BITS-1:0] + ONE_M0;
            if (&lo_q[M0_LO_BITS-1:0]) begin
               hi_d     = hi_q + ONE_B;
               main_raw = &hi_q;
            end
         end
         MD_16BIT: if (cnt_en) begin
            {hi_d, lo_d} = wide_nx;
            main_raw     = &{hi_q, lo_q};
         end
         MD_RELOAD: if (cnt_en) begin
            if (&lo_q) begin
               lo_d     = hi_q;
               main_raw = 1'b1;
            end else begin
               lo_d = lo_q + ONE_B;
            end
         end
         MD_SPLIT: if (SPLIT_OK) begin
            if (cnt_en) begin
               lo_d     = lo_q + ONE_B;
               main_raw = &lo_q;
            end
            if (hi_en) begin
               hi_d      = hi_q + ONE_B;
               split_raw = &hi_q;
            end
         end
      endcase
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
   end

   // a written byte does not report the overflow it replaced
   assign ovf_main  = main_raw & ~wr_lo & ~((mode != MD_SPLIT) & wr_hi);
   assign ovf_split = split_raw & ~wr_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end
endmodule

// File: rtl/tmr_pair_unit.sv
module tmr_pair_unit
   import tmr_pair_pkg::*;
#(
   parameter int PRESCALE   = 12,
   parameter int M0_LO_BITS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_we,
   input  logic [2:0] cpu_addr,
   input  logic [7:0] cpu_wdata,
   output logic [7:0] cpu_rdata,
   input  logic [1:0] gate_pin,
   input  logic [1:0] cnt_pin,
   input  logic [1:0] irq_ack,
   output logic [1:0] ovf_flag
);
   localparam int NCH = 2;

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("tmr_pair_unit: PRESCALE must be at least 2");
   end
   if (M0_LO_BITS < 1 || M0_LO_BITS > BYTE_W) begin : g_bad_m0
      $error("tmr_pair_unit: M0_LO_BITS must lie in 1..BYTE_W");
   end

   chcfg_t [NCH-1:0] cfg_q;
   logic [NCH-1:0]   run_q, flag_q;
   logic             mc_tick, split_on;
   logic [NCH-1:0]   pin_fall, cnt_en, hi_en, run_eff;
   logic [NCH-1:0]   ovf_main, ovf_split, ovf_set;
   byte_t            lo_q [NCH];
   byte_t            hi_q [NCH];
   logic             wr_mode, wr_ctrl;

   assign split_on = (cfg_q[0].mode == MD_SPLIT);
   assign wr_mode  = cpu_we && (cpu_addr == A_MODE);
   assign wr_ctrl  = cpu_we && (cpu_addr == A_CTRL);

   tmr_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic src_evt, gate_ok;

      tmr_fall_det u_fall (
         .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]), .fall(pin_fall[i])
      );

      assign src_evt = cfg_q[i].ext_src ? pin_fall[i] : mc_tick;
      assign gate_ok = ~cfg_q[i].gate_en | gate_pin[i];

      if (i == 0) begin : g_lead
         assign run_eff[i] = run_q[0];
         assign hi_en[i]   = split_on & run_q[1] & mc_tick;
      end else begin : g_follow
         assign run_eff[i] = run_q[i] & ~split_on;
         assign hi_en[i]   = 1'b0;
      end

      assign cnt_en[i] = run_eff[i] & gate_ok & src_evt;

      tmr_channel #(.SPLIT_OK(i == 0), .M0_LO_BITS(M0_LO_BITS)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (cfg_q[i].mode),
         .cnt_en   (cnt_en[i]),
         .hi_en    (hi_en[i]),
         .wr_lo    (cpu_we && (cpu_addr == 3'(2*i))),
         .wr_hi    (cpu_we && (cpu_addr == 3'(2*i+1))),
         .wdata    (cpu_wdata),
         .lo_q     (lo_q[i]),
         .hi_q     (hi_q[i]),
         .ovf_main (ovf_main[i]),
         .ovf_split(ovf_split[i])
      );
   end

   // the split high byte reports through flag 1
   assign ovf_set[0] = ovf_main[0];
   assign ovf_set[1] = ovf_main[1] | ovf_split[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         run_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_mode) cfg_q <= cpu_wdata;
         if (wr_ctrl) run_q <= cpu_wdata[1:0];
         for (int k = 0; k < NCH; k++) begin
            if (wr_ctrl)         flag_q[k] <= cpu_wdata[2+k];
            else if (ovf_set[k]) flag_q[k] <= 1'b1;
            else if (irq_ack[k]) flag_q[k] <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (cpu_addr)
         A_LO0:   cpu_rdata = lo_q[0];
         A_HI0:   cpu_rdata = hi_q[0];
         A_LO1:   cpu_rdata = lo_q[1];
         A_HI1:   cpu_rdata = hi_q[1];
         A_MODE:  cpu_rdata = cfg_q;
         A_CTRL:  cpu_rdata = {4'b0000, flag_q, run_q};
         default: cpu_rdata = '0;
      endcase
   end

   assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
   import tmr_pair_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_we,
   input logic [2:0] cpu_addr,
   input logic [7:0] cpu_wdata,
   input logic [1:0] irq_ack,
   input logic [1:0] ovf_flag,
   input logic [1:0] ovf_set,
   input logic [1:0] run,
   input logic [1:0] mode0,
   input logic [1:0] mode1,
   input logic [7:0] lo0,
   input logic [7:0] hi0,
   input logic [7:0] lo1,
   input logic [7:0] hi1
);
   logic wr_c0, wr_c1, wr_hi0, wr_lo0, wr_ctl;
   assign wr_lo0 = cpu_we && (cpu_addr == A_LO0);
   assign wr_hi0 = cpu_we && (cpu_addr == A_HI0);
   assign wr_c0  = wr_lo0 || wr_hi0;
   assign wr_c1  = cpu_we && ((cpu_addr == A_LO1) || (cpu_addr == A_HI1));
   assign wr_ctl = cpu_we && (cpu_addr == A_CTRL);

   assert_rst_clears_R2: assert property (@(posedge clk)
      !rst_n |=> (ovf_flag == 2'b00));

   assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[0] && mode0 != 2'd3 && !wr_c0) |=> ($stable(lo0) && $stable(hi0)));

   assert_reload_hi_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode0 == 2'd2 && !wr_hi0) |=> $stable(hi0));

   // R8 and R9: channel 1 frozen in its own split mode or when channel 0 splits
   assert_ch1_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode1 == 2'd3 || mode0 == 2'd3) && !wr_c1) |=> ($stable(lo1) && $stable(hi1)));

   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo0 |=> (lo0 == $past(cpu_wdata)));

   assert_ack0_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[0] && !ovf_set[0] && !wr_ctl) |=> !ovf_flag[0]);

   assert_ack1_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[1] && !ovf_set[1] && !wr_ctl) |=> !ovf_flag[1]);

   assert_ovf0_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_set[0] && !wr_ctl) |=> ovf_flag[0]);

   assert_ovf1_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_set[1] && !wr_ctl) |=> ovf_flag[1]);
endmodule

bind tmr_pair_unit tmr_pair_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_we   (cpu_we),
   .cpu_addr (cpu_addr),
   .cpu_wdata(cpu_wdata),
   .irq_ack  (irq_ack),
   .ovf_flag (ovf_flag),
   .ovf_set  (ovf_set),
   .run      (run_q),
   .mode0    (cfg_q[0].mode),
   .mode1    (cfg_q[1].mode),
   .lo0      (lo_q[0]),
   .hi0      (hi_q[0]),
   .lo1      (lo_q[1]),
   .hi1      (hi_q[1])
);

// File: tb/sim_tmr_pair_unit.sv
module sim_tmr_pair_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_we = 1'b0;
   logic [2:0] cpu_addr = 3'd0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic [1:0] gate_pin = 2'b00;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] irq_ack = 2'b00;
   logic [1:0] ovf_flag;

   localparam int PIN = 8;   // scoreboard code for the flag outputs

   typedef struct {
      int         what;
      logic [7:0] exp;
      string      req;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     probe_ev;
   int       n_vec = 0;
   int       n_bad = 0;
   bit       done  = 1'b0;

   always #5 clk = ~clk;

   tmr_pair_unit u0 (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .gate_pin(gate_pin),
      .cnt_pin(cnt_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
   );

   // monitor: pops expected items and compares them in mid-cycle
   initial begin
      forever begin
         @(probe_ev);
         #1;
         if (sb_q.size() != 0) begin
            sb_item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = (it.what == PIN) ? {6'b0, ovf_flag} : cpu_rdata;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: item %0d got %h expected %h", it.req, it.what, act, it.exp);
            end
         end
      end
   end

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

   // driver tasks: called at a falling edge, return at a falling edge
   task automatic chk(int what, logic [7:0] exp, string req);
      sb_item_t it;
      if (what < PIN) cpu_addr = what[2:0];
      it.what = what; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      ->probe_ev;
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic pulse(int ch);
      cnt_pin[ch] = 1'b0;
      @(negedge clk);
      cnt_pin[ch] = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state, R1 reserved reads
      for (int a = 0; a < 8; a++) chk(a, 8'h00, "R2");
      chk(PIN, 8'h00, "R2");

      // R6 16-bit pin count, R10 run does not clear, R4 pin source
      wr(3'd4, 8'h05);
      wr(3'd0, 8'hFE);
      wr(3'd1, 8'hFF);
      wr(3'd5, 8'h01);
      chk(0, 8'hFE, "R10");
      chk(1, 8'hFF, "R10");
      pulse(0);
      chk(0, 8'hFF, "R4");
      chk(PIN, 8'h00, "R6");
      pulse(0);
      chk(0, 8'h00, "R6");
      chk(1, 8'h00, "R6");
      chk(5, 8'h05, "R6");
      chk(PIN, 8'h01, "R6");

      // R11 clear by writing 0
      wr(3'd5, 8'h01);
      chk(PIN, 8'h00, "R11");

      // R5 13-bit mode, upper low-byte bits kept
      wr(3'd5, 8'h00);
      wr(3'd4, 8'h04);
      wr(3'd0, 8'hFE);
      wr(3'd1, 8'hFF);
      wr(3'd5, 8'h01);
      pulse(0);
      chk(0, 8'hFF, "R5");
      chk(PIN, 8'h00, "R5");
      pulse(0);
      chk(0, 8'hE0, "R5");
      chk(1, 8'h00, "R5");
      chk(PIN, 8'h01, "R5");
      irq_ack[0] = 1'b1;
      @(negedge clk);
      irq_ack[0] = 1'b0;
      chk(PIN, 8'h00, "R11");

      // R3 gating and run bit
      wr(3'd5, 8'h00);
      wr(3'd4, 8'h0D);
      wr(3'd0, 8'h10);
      wr(3'd1, 8'h00);
      gate_pin[0] = 1'b0;
      wr(3'd5, 8'h01);
      pulse(0);
      pulse(0);
      chk(0, 8'h10, "R3");
      gate_pin[0] = 1'b1;
      pulse(0);
      chk(0, 8'h11, "R3");
      wr(3'd5, 8'h00);
      pulse(0);
      chk(0, 8'h11, "R3");

      // R12 write beats a same-cycle increment
      wr(3'd4, 8'h05);
      wr(3'd5, 8'h01);
      cnt_pin[0] = 1'b0;
      @(negedge clk);
      cnt_pin[0] = 1'b1;
      cpu_we = 1'b1; cpu_addr = 3'd0; cpu_wdata = 8'h55;
      @(negedge clk);
      cpu_we = 1'b0;
      @(negedge clk);
      chk(0, 8'h55, "R12");
      pulse(0);
      chk(0, 8'h56, "R4");

      // R7 reload mode on channel 1
      wr(3'd5, 8'h00);
      wr(3'd4, 8'h60);
      wr(3'd3, 8'h80);
      wr(3'd2, 8'hFE);
      wr(3'd5, 8'h02);
      pulse(1);
      pulse(1);
      chk(2, 8'h80, "R7");
      chk(3, 8'h80, "R7");
      chk(PIN, 8'h02, "R7");
      pulse(1);
      chk(2, 8'h81, "R7");
      chk(3, 8'h80, "R7");
      wr(3'd5, 8'h00);
      chk(PIN, 8'h00, "R11");

      // R4 machine cycles: 60 counted edges give 5 steps
      wr(3'd4, 8'h10);
      wr(3'd2, 8'h00);
      wr(3'd3, 8'h00);
      wr(3'd5, 8'h02);
      repeat (59) @(negedge clk);
      wr(3'd5, 8'h00);
      chk(2, 8'h05, "R4");
      chk(3, 8'h00, "R4");

      // R8 split mode: 36 edges give 3 high-byte ticks, channel 1 frozen
      wr(3'd4, 8'h17);
      wr(3'd0, 8'hFE);
      wr(3'd1, 8'hFE);
      wr(3'd2, 8'h40);
      wr(3'd3, 8'h00);
      wr(3'd5, 8'h03);
      repeat (34) @(negedge clk);
      chk(PIN, 8'h02, "R8");
      wr(3'd5, 8'h09);
      chk(1, 8'h01, "R8");
      chk(0, 8'hFE, "R8");
      chk(2, 8'h40, "R8");
      chk(3, 8'h00, "R8");
      pulse(0);
      pulse(0);
      chk(0, 8'h00, "R8");
      chk(5, 8'h0D, "R8");
      chk(PIN, 8'h03, "R8");

      // R9 channel 1 in its own split mode holds
      wr(3'd5, 8'h00);
      wr(3'd4, 8'h31);
      wr(3'd2, 8'h33);
      wr(3'd3, 8'h44);
      wr(3'd5, 8'h02);
      repeat (30) @(negedge clk);
      chk(2, 8'h33, "R9");
      chk(3, 8'h44, "R9");
      chk(PIN, 8'h00, "R9");

      // R11 set by write, clear by acknowledge on channel 1
      wr(3'd5, 8'h08);
      chk(PIN, 8'h02, "R11");
      irq_ack[1] = 1'b1;
      @(negedge clk);
      irq_ack[1] = 1'b0;
      chk(PIN, 8'h00, "R11");

      // R1 mode byte readback
      wr(3'd4, 8'hA5);
      chk(4, 8'hA5, "R1");

      repeat (2) @(negedge clk);
      done = 1'b1;
      report();
   end
endmodule